// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Guard

This block is the device-side status register and write-guard logic of a serial NOR flash. The command decoder gives it one-cycle strobes: write enable, write disable, status write with a data byte, page program, sector erase, bulk erase, sleep and wake. It also receives the level of the active-low write-protect pin and the index of the sector a program or erase targets. It holds the busy flag, the write-enable latch, four protection-range bits and a status-lock bit. For each modifying command it decides whether the command is accepted or refused, and it models the time the operation takes with a down-counter.

An accepted command raises `acceptPulse` for one cycle and a refused one raises `rejectPulse`. Both pulses appear in the cycle after the strobe. The surrounding flash uses `acceptPulse` to start the real array operation, and software polls the status byte until the busy bit drops. The array itself and the serial shifting are handled elsewhere. At most one strobe is asserted in any cycle.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and `asleep` is 0. Status layout: bit0 busy, bit1 write-enable latch, bits 5:2 protection code, bit6 always 0, bit7 status lock.
- R2: The write-enable strobe sets the latch (bit1) at the next clock edge, and the write-disable strobe clears it.
- R3: A status write, program or erase that arrives while the latch is 0 is refused: `rejectPulse` rises and no status bit changes.
- R4: An accepted command sets busy for exactly TWrStat, TProg, TSectErase or TBulkErase cycles, according to the command. `acceptPulse` is high in the first of those cycles.
- R5: When busy ends, the write-enable latch is cleared.
- R6: A refused command clears the write-enable latch and leaves every other status bit unchanged.
- R7: The protection code P covers the top (NumSectors >> (15-P)) sectors. Code 0 covers none and code 15 covers all. Program or sector erase to a covered sector is refused. Bulk erase is refused whenever any sector is covered.
- R8: An accepted status write loads bits 5:2 and bit7 from the data byte when busy starts. The other data bits are ignored.
- R9: While the status lock is 1 and the write-protect pin is low, a status write is refused and bits 7:2 stay unchanged.
- R10: While busy, every strobe is ignored: no pulse is produced and no status bit changes.
- R11: The sleep strobe, given when not busy, sets `asleep`. While asleep every strobe except wake is ignored. Wake clears `asleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEnStb | input | 1 | Write-enable strobe |
| wrDisStb | input | 1 | Write-disable strobe |
| statWrStb | input | 1 | Status write strobe |
| statData | input | 8 | Data byte for status write |
| progStb | input | 1 | Page program strobe |
| sectEraseStb | input | 1 | Sector erase strobe |
| bulkEraseStb | input | 1 | Bulk erase strobe |
| sleepStb | input | 1 | Enter deep power-down |
| wakeStb | input | 1 | Leave deep power-down |
| wpN | input | 1 | Write-protect pin, active low |
| sectorIdx | input | SectBits | Target sector of program or sector erase |
| statusReg | output | 8 | Status byte |
| acceptPulse | output | 1 | Command accepted (one cycle) |
| rejectPulse | output | 1 | Command refused (one cycle) |
| asleep | output | 1 | Deep power-down active |

## Verification
Programs are aimed at sectors just below and just above the edge of the covered range for several protection codes: half the array, one sector, everything, and a code too small to cover anything. This separates an off-by-one range edge from a wrong shift. The same status write is tried with the pin high and low and with the lock set and clear, so a lock that ignores the pin can be told apart from one that ignores the lock bit. Busy lengths are counted for each command kind, which catches a swapped count or a counter that is one cycle off. Strobes given while busy and while asleep show whether the state can still be disturbed.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
  } ctrlStb_t;

  typedef enum logic [1:0] {
    OpStat  = 2'd0,
    OpProg  = 2'd1,
    OpSect  = 2'd2,
    OpBulk  = 2'd3
  } opKind_t;
endpackage

// File: rtl/fsg_datapath.sv
module fsg_datapath
  import fsg_pkg::*;
#(
  parameter int SectBits = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  input  logic [7:0]          statData,
  input  logic [SectBits-1:0] sectorIdx,
  input  logic                wpN,
  output logic                welQ,
  output logic [3:0]          protQ,
  output logic                lockQ,
  output logic                protHit,
  output logic                anyProt,
  output logic                hwLock
);
  localparam int NumSectors = 1 << SectBits;

  int unsigned coverCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ  <= 1'b0;
      protQ <= 4'd0;
      lockQ <= 1'b0;
    end else begin
      if (stb.setWel)      welQ <= 1'b1;
      else if (stb.clrWel) welQ <= 1'b0;
      if (stb.loadStat) begin
        protQ <= statData[5:2];
        lockQ <= statData[7];
      end
    end
  end

  always_comb begin
    coverCnt = NumSectors >> (32'd15 - 32'(protQ));
    anyProt  = (coverCnt != 0);
    protHit  = (32'(sectorIdx) >= (NumSectors - coverCnt)) && anyProt;
    hwLock   = lockQ && !wpN;
  end
endmodule

// File: rtl/fsg_control.sv
module fsg_control
  import fsg_pkg::*;
#(
  parameter int TWrStat    = 4,
  parameter int TProg      = 6,
  parameter int TSectErase = 12,
  parameter int TBulkErase = 20
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEnStb,
  input  logic     wrDisStb,
  input  logic     statWrStb,
  input  logic     progStb,
  input  logic     sectEraseStb,
  input  logic     bulkEraseStb,
  input  logic     sleepStb,
  input  logic     wakeStb,
  input  logic     welQ,
  input  logic     protHit,
  input  logic     anyProt,
  input  logic     hwLock,
  output ctrlStb_t stb,
  output logic     busy,
  output logic     asleep,
  output logic     acceptPulse,
  output logic     rejectPulse
);
  localparam int MaxA = (TWrStat > TProg) ? TWrStat : TProg;
  localparam int MaxB = (TSectErase > TBulkErase) ? TSectErase : TBulkErase;
  localparam int MaxT = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int CntW = $clog2(MaxT + 1);

  logic [CntW-1:0] cnt;
  logic            startOp, refuse, goSleep, goWake;
  opKind_t         op;
  logic [CntW-1:0] loadVal;

  always_comb begin
    stb     = '0;
    startOp = 1'b0;
    refuse  = 1'b0;
    goSleep = 1'b0;
    goWake  = 1'b0;
    op      = OpStat;
    if (busy) begin
      stb.clrWel = (cnt == '0);
    end else if (asleep) begin
      goWake = wakeStb;
    end else if (wrEnStb) begin
      stb.setWel = 1'b1;
    end else if (wrDisStb) begin
      stb.clrWel = 1'b1;
    end else if (statWrStb) begin
      op = OpStat;
      if (welQ && !hwLock) begin
        startOp      = 1'b1;
        stb.loadStat = 1'b1;
      end else refuse = 1'b1;
    end else if (progStb || sectEraseStb) begin
      op = progStb ? OpProg : OpSect;
      if (welQ && !protHit) startOp = 1'b1;
      else refuse = 1'b1;
    end else if (bulkEraseStb) begin
      op = OpBulk;
      if (welQ && !anyProt) startOp = 1'b1;
      else refuse = 1'b1;
    end else if (sleepStb) begin
      goSleep = 1'b1;
    end
    if (refuse) stb.clrWel = 1'b1;
  end

  always_comb begin
    unique case (op)
      OpStat:  loadVal = CntW'(TWrStat - 1);
      OpProg:  loadVal = CntW'(TProg - 1);
      OpSect:  loadVal = CntW'(TSectErase - 1);
      default: loadVal = CntW'(TBulkErase - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      cnt         <= '0;
      asleep      <= 1'b0;
      acceptPulse <= 1'b0;
      rejectPulse <= 1'b0;
    end else begin
      acceptPulse <= startOp;
      rejectPulse <= refuse;
      if (startOp) begin
        busy <= 1'b1;
        cnt  <= loadVal;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else cnt <= cnt - 1'b1;
      end
      if (goSleep)     asleep <= 1'b1;
      else if (goWake) asleep <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
  import fsg_pkg::*;
#(
  parameter int SectBits   = 6,
  parameter int TWrStat    = 4,
  parameter int TProg      = 6,
  parameter int TSectErase = 12,
  parameter int TBulkErase = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEnStb,
  input  logic                wrDisStb,
  input  logic                statWrStb,
  input  logic [7:0]          statData,
  input  logic                progStb,
  input  logic                sectEraseStb,
  input  logic                bulkEraseStb,
  input  logic                sleepStb,
  input  logic                wakeStb,
  input  logic                wpN,
  input  logic [SectBits-1:0] sectorIdx,
  output logic [7:0]          statusReg,
  output logic                acceptPulse,
  output logic                rejectPulse,
  output logic                asleep
);
  ctrlStb_t   stb;
  logic       welQ, lockQ, protHit, anyProt, hwLock, busy;
  logic [3:0] protQ;

  fsg_datapath #(.SectBits(SectBits)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .statData(statData),
    .sectorIdx(sectorIdx), .wpN(wpN), .welQ(welQ), .protQ(protQ),
    .lockQ(lockQ), .protHit(protHit), .anyProt(anyProt), .hwLock(hwLock)
  );

  fsg_control #(
    .TWrStat(TWrStat), .TProg(TProg),
    .TSectErase(TSectErase), .TBulkErase(TBulkErase)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .wrEnStb(wrEnStb), .wrDisStb(wrDisStb),
    .statWrStb(statWrStb), .progStb(progStb), .sectEraseStb(sectEraseStb),
    .bulkEraseStb(bulkEraseStb), .sleepStb(sleepStb), .wakeStb(wakeStb),
    .welQ(welQ), .protHit(protHit), .anyProt(anyProt), .hwLock(hwLock),
    .stb(stb), .busy(busy), .asleep(asleep),
    .acceptPulse(acceptPulse), .rejectPulse(rejectPulse)
  );

  assign statusReg = {lockQ, 1'b0, protQ, welQ, busy};
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       wpN,
  input logic [7:0] statusReg,
  input logic       acceptPulse,
  input logic       rejectPulse,
  input logic       asleep
);
  // R6
  reject_clears_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectPulse |-> !statusReg[1]);

  // R4
  busy_start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[0]) |-> acceptPulse);

  // R5
  busy_end_clears_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[0]) |-> !statusReg[1]);

  // R3
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptPulse && rejectPulse));

  // R11
  sleep_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    asleep |-> !statusReg[0]);

  // R9
  hw_lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[7] && !wpN) |=> $stable(statusReg[7:2]));

  // R1
  bit6_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[0]) |-> !statusReg[6]);
endmodule

bind flash_status_guard fsg_checker chk_i (
  .clk(clk), .rstN(rstN), .wpN(wpN), .statusReg(statusReg),
  .acceptPulse(acceptPulse), .rejectPulse(rejectPulse), .asleep(asleep)
);

// File: tb/flash_status_guard_tb_top.sv
module flash_status_guard_tb_top;
  localparam int SB = 6;
  localparam int TW = 4, TP = 6, TS = 12, TB = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0, wrDis = 0, statWr = 0, prog = 0, sectEr = 0, bulkEr = 0, slp = 0, wake = 0;
  logic wpN = 1'b1;
  logic [7:0] statData = '0;
  logic [SB-1:0] sector = '0;
  logic [7:0] status;
  logic acc, rej, asleep;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  flash_status_guard #(.SectBits(SB), .TWrStat(TW), .TProg(TP),
                       .TSectErase(TS), .TBulkErase(TB)) dut_i (
    .clk(clk), .rstN(rstN), .wrEnStb(wrEn), .wrDisStb(wrDis),
    .statWrStb(statWr), .statData(statData), .progStb(prog),
    .sectEraseStb(sectEr), .bulkEraseStb(bulkEr), .sleepStb(slp),
    .wakeStb(wake), .wpN(wpN), .sectorIdx(sector), .statusReg(status),
    .acceptPulse(acc), .rejectPulse(rej), .asleep(asleep)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // 0 wrEn 1 wrDis 2 statWr 3 prog 4 sectEr 5 bulkEr 6 sleep 7 wake
  task automatic fire(input int kind, input logic [7:0] d, input int sec,
                      output logic a, output logic r);
    statData = d;
    sector = SB'(sec);
    case (kind)
      0: wrEn = 1; 1: wrDis = 1; 2: statWr = 1; 3: prog = 1;
      4: sectEr = 1; 5: bulkEr = 1; 6: slp = 1; default: wake = 1;
    endcase
    @(negedge clk);
    {wrEn, wrDis, statWr, prog, sectEr, bulkEr, slp, wake} = '0;
    a = acc;
    r = rej;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (status[0] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic setProt(input logic [7:0] v);
    logic a, r;
    int n;
    fire(0, 0, 0, a, r);
    fire(2, v, 0, a, r);
    check("R8 accept", a, 1);
    busyLen(n);
    check("R8 status", status, {v[7], 1'b0, v[5:2], 2'b00});
  endtask

  task automatic testReset();
    check("R1 status", status, 8'h00);
    check("R1 asleep", asleep, 0);
  endtask

  task automatic testLatch();
    logic a, r;
    fire(0, 0, 0, a, r);
    check("R2 set", status, 8'h02);
    fire(1, 0, 0, a, r);
    check("R2 clear", status, 8'h00);
  endtask

  task automatic testNoLatch();
    logic a, r;
    fire(3, 0, 0, a, r);
    check("R3 reject", r, 1);
    check("R3 no accept", a, 0);
    check("R3 status", status, 8'h00);
    fire(2, 8'h3C, 0, a, r);
    check("R3 statwr reject", r, 1);
    check("R3 statwr status", status, 8'h00);
  endtask

  task automatic testTimes();
    logic a, r;
    int n;
    fire(0, 0, 0, a, r);
    fire(3, 0, 5, a, r);
    check("R4 prog accept", a, 1);
    check("R4 busy+wel", status, 8'h03);
    busyLen(n);
    check("R4 prog len", n, TP);
    check("R5 wel clear", status, 8'h00);
    fire(0, 0, 0, a, r);
    fire(4, 0, 63, a, r);
    busyLen(n);
    check("R4 sect len", n, TS);
    fire(0, 0, 0, a, r);
    fire(5, 0, 0, a, r);
    check("R4 bulk accept", a, 1);
    busyLen(n);
    check("R4 bulk len", n, TB);
    check("R5 wel clear bulk", status, 8'h00);
    fire(0, 0, 0, a, r);
    fire(2, 8'h43, 0, a, r);
    check("R8 during busy", status, 8'h03);
    busyLen(n);
    check("R4 statwr len", n, TW);
  endtask

  task automatic testRanges();
    logic a, r;
    int n;
    setProt(8'h38);
    fire(0, 0, 0, a, r);
    fire(3, 0, 32, a, r);
    check("R7 half edge reject", r, 1);
    check("R6 wel cleared", status, 8'h38);
    fire(0, 0, 0, a, r);
    fire(3, 0, 31, a, r);
    check("R7 half below accept", a, 1);
    busyLen(n);
    fire(0, 0, 0, a, r);
    fire(5, 0, 0, a, r);
    check("R7 bulk refused", r, 1);
    setProt(8'h24);
    fire(0, 0, 0, a, r);
    fire(4, 0, 63, a, r);
    check("R7 one sector reject", r, 1);
    fire(0, 0, 0, a, r);
    fire(4, 0, 62, a, r);
    check("R7 one below accept", a, 1);
    busyLen(n);
    setProt(8'h3C);
    fire(0, 0, 0, a, r);
    fire(3, 0, 0, a, r);
    check("R7 all reject", r, 1);
    setProt(8'h20);
    fire(0, 0, 0, a, r);
    fire(3, 0, 63, a, r);
    check("R7 small code none", a, 1);
    busyLen(n);
    setProt(8'h00);
  endtask

  task automatic testLock();
    logic a, r;
    setProt(8'hB8);
    wpN = 0;
    fire(0, 0, 0, a, r);
    fire(2, 8'h00, 0, a, r);
    check("R9 locked reject", r, 1);
    check("R9 bits held", status, 8'hB8);
    wpN = 1;
    setProt(8'h00);
    wpN = 0;
    setProt(8'h10);
    wpN = 1;
    setProt(8'h00);
  endtask

  task automatic testBusyIgnore();
    logic a, r;
    int n;
    fire(0, 0, 0, a, r);
    fire(4, 0, 1, a, r);
    fire(1, 0, 0, a, r);
    check("R10 wrdis ignored", status, 8'h03);
    fire(3, 0, 2, a, r);
    check("R10 no pulse", {a, r}, 0);
    fire(6, 0, 0, a, r);
    check("R10 sleep ignored", asleep, 0);
    busyLen(n);
    check("R10 len intact", n, TS - 3);
  endtask

  task automatic testSleep();
    logic a, r;
    int n;
    fire(0, 0, 0, a, r);
    fire(6, 0, 0, a, r);
    check("R11 asleep", asleep, 1);
    fire(3, 0, 0, a, r);
    check("R11 prog ignored", {a, r}, 0);
    fire(1, 0, 0, a, r);
    check("R11 wel kept", status, 8'h02);
    fire(7, 0, 0, a, r);
    check("R11 woke", asleep, 0);
    fire(3, 0, 0, a, r);
    check("R11 prog after wake", a, 1);
    busyLen(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testLatch();
    testNoLatch();
    testTimes();
    testRanges();
    testLock();
    testBusyIgnore();
    testSleep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule